// File: doc/BRIEF.md
# Privilege-Aware Interrupt Priority Selector

This block holds a pending flag for each of seven interrupt sources and, on request, names the one the processor should take next. The sources are trap-level-zero, tick-compare match, interrupt vector, CPU mondo, device mondo, resumable error and software interrupt. A source raises its flag with a one-cycle pulse on its post line. The flag stays set until the selector grants that source.

When the core asserts `take_i`, the block samples the processor state inputs in that cycle. These are the hyperprivileged bit, the interrupt-enable bit, the trap-level-zero enable, the trap level, the processor interrupt level and the software-interrupt register. From them it picks the highest-ranked eligible source and clears that source's flag at the same clock edge. In the following cycle it reports the grant as a one-cycle strobe with a one-hot source vector, an encoded source and, for software interrupts, the level number.

The result path has no ready input. The consumer must accept every `cause_vld_o` strobe in the cycle it appears, because the flag is already gone by then. Back-pressure is applied by holding `take_i` low. Computing the vector, updating processor registers and delivering the vector payload are left to the surrounding logic.

Top module: `irq_prio_sel`

## Requirements
- R1: A one-cycle pulse on `post_i[k]` sets pending flag k at the next edge. `pend_any_o` is high exactly when some flag in `pend_o` is set. Bit positions: 0 trap-level-zero, 1 tick match, 2 vector, 3 CPU mondo, 4 device mondo, 5 resumable error, 6 software interrupt. `cause_code_o` uses the same numbers.
- R2: Synchronous active-high `rst` clears all flags, `pend_any_o` and `cause_vld_o`.
- R3: With `hpriv_i` high, only tick match, and after it vector, can be granted, and only when `ie_i` is high. Every other source stays pending.
- R4: With `hpriv_i` low, trap-level-zero has the top rank. It is granted only when `tlz_en_i` is high and `tl_i` is zero.
- R5: With `hpriv_i` low, tick match ranks next and is granted whatever the value of `ie_i`.
- R6: With `hpriv_i` low and `ie_i` high, the sources after tick match rank as follows: CPU mondo, device mondo, software interrupt, resumable error.
- R7: The software level is the index of the highest set bit among bits 15..1 of `softint_i`. Bit 0 is ignored, and a level of 0 means no level is set.
- R8: When software interrupt is pending, its level is below 6 and vector is pending, vector is granted in the software slot.
- R9: Otherwise software interrupt is granted only if its level is strictly above `pil_i`, and `cause_lvl_o` carries that level. If it is not granted, the selection moves on to resumable error.
- R10: A grant clears the granted flag at the sampling edge. The software flag is cleared only if no bit of 15..1 other than the granted level is set.
- R11: When no source is eligible, `cause_vld_o` stays low and no flag changes.
- R12: A post and a grant of the same source in the same cycle leave its flag set.
- R13: `cause_vld_o` pulses in the cycle after the sampling `take_i`, with exactly one bit set in `cause_src_o`, matching `cause_code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_i | input | 7 | Per-source post pulses |
| take_i | input | 1 | Request to select and grant one source |
| hpriv_i | input | 1 | Hyperprivileged mode |
| ie_i | input | 1 | Interrupt enable |
| tlz_en_i | input | 1 | Trap-level-zero interrupt enable |
| tl_i | input | 3 | Current trap level |
| pil_i | input | 4 | Processor interrupt level |
| softint_i | input | 16 | Software-interrupt register |
| cause_vld_o | output | 1 | Grant strobe |
| cause_src_o | output | 7 | One-hot granted source |
| cause_code_o | output | 3 | Encoded granted source |
| cause_lvl_o | output | 4 | Software level of the grant, else 0 |
| pend_o | output | 7 | Pending flags |
| pend_any_o | output | 1 | Any flag pending |

## Verification
A corrupted flag appears on `pend_o` one cycle after the post or grant that caused it. It then misdirects the next grant, where the wrong source or a missing strobe shows up one cycle after `take_i`. An error in ranking or eligibility shows up immediately as a wrong `cause_code_o` or a wrong level. If the software-flag clearing rule is wrong, the flag stays set or drops too early, and `pend_o` reveals this one cycle later. The sweep covers every flag pattern under every mode combination, with software registers chosen to sit on both sides of the vector threshold and of the interrupt level.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int N_SRC  = 7;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    SRC_TLZ  = 3'd0,
    SRC_TICK = 3'd1,
    SRC_VEC  = 3'd2,
    SRC_CPU  = 3'd3,
    SRC_DEV  = 3'd4,
    SRC_RERR = 3'd5,
    SRC_SOFT = 3'd6
  } src_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] post_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (rst) flag_q <= 1'b0;
      else     flag_q <= (flag_q & ~clr_i[k]) | post_i[k];
    end
    assign pend_o[k] = flag_q;
  end
endmodule

// File: rtl/irq_lvl_enc.sv
module irq_lvl_enc #(
  parameter int SI_W  = 16,
  parameter int LVL_W = $clog2(SI_W)
) (
  input  logic [SI_W-1:0]  si_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             rest_any_o
);
  logic [SI_W-1:0] rest;

  always_comb begin
    lvl_o = '0;
    for (int i = 1; i < SI_W; i++) begin
      if (si_i[i]) lvl_o = LVL_W'(i);
    end
  end

  always_comb begin
    rest        = si_i;
    rest[0]     = 1'b0;
    rest[lvl_o] = 1'b0;
  end

  assign rest_any_o = |rest;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_sel_pkg::*;
#(
  parameter int LVL_W   = 4,
  parameter int TL_W    = 3,
  parameter int VEC_LIM = 6
) (
  input  logic [N_SRC-1:0]  pend_i,
  input  logic              hpriv_i,
  input  logic              ie_i,
  input  logic              tlz_en_i,
  input  logic [TL_W-1:0]   tl_i,
  input  logic [LVL_W-1:0]  pil_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output logic              hit_o,
  output src_e              code_o,
  output logic [LVL_W-1:0]  lvl_o
);
  logic soft_vec;
  logic soft_lvl;

  assign soft_vec = pend_i[SRC_SOFT] && (lvl_i < LVL_W'(VEC_LIM)) && pend_i[SRC_VEC];
  assign soft_lvl = pend_i[SRC_SOFT] && (lvl_i > pil_i);

  always_comb begin
    hit_o  = 1'b1;
    code_o = SRC_TLZ;
    lvl_o  = '0;
    if (hpriv_i) begin
      if (ie_i && pend_i[SRC_TICK])     code_o = SRC_TICK;
      else if (ie_i && pend_i[SRC_VEC]) code_o = SRC_VEC;
      else                              hit_o  = 1'b0;
    end else if (pend_i[SRC_TLZ] && tlz_en_i && (tl_i == '0)) begin
      code_o = SRC_TLZ;
    end else if (pend_i[SRC_TICK]) begin
      code_o = SRC_TICK;
    end else if (!ie_i) begin
      hit_o = 1'b0;
    end else if (pend_i[SRC_CPU]) begin
      code_o = SRC_CPU;
    end else if (pend_i[SRC_DEV]) begin
      code_o = SRC_DEV;
    end else if (soft_vec) begin
      code_o = SRC_VEC;
    end else if (soft_lvl) begin
      code_o = SRC_SOFT;
      lvl_o  = lvl_i;
    end else if (pend_i[SRC_RERR]) begin
      code_o = SRC_RERR;
    end else begin
      hit_o = 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_sel_pkg::*;
#(
  parameter int SI_W    = 16,
  parameter int TL_W    = 3,
  parameter int VEC_LIM = 6,
  localparam int LVL_W  = $clog2(SI_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  post_i,
  input  logic              take_i,
  input  logic              hpriv_i,
  input  logic              ie_i,
  input  logic              tlz_en_i,
  input  logic [TL_W-1:0]   tl_i,
  input  logic [LVL_W-1:0]  pil_i,
  input  logic [SI_W-1:0]   softint_i,
  output logic              cause_vld_o,
  output logic [N_SRC-1:0]  cause_src_o,
  output logic [CODE_W-1:0] cause_code_o,
  output logic [LVL_W-1:0]  cause_lvl_o,
  output logic [N_SRC-1:0]  pend_o,
  output logic              pend_any_o
);
  logic [LVL_W-1:0] si_lvl;
  logic             si_rest;
  logic             hit;
  src_e             code;
  logic [LVL_W-1:0] hit_lvl;
  logic [N_SRC-1:0] grant;
  logic [N_SRC-1:0] clr;

  irq_pend_bank #(.N(N_SRC)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .post_i (post_i),
    .clr_i  (clr),
    .pend_o (pend_o)
  );

  irq_lvl_enc #(.SI_W(SI_W), .LVL_W(LVL_W)) u_enc (
    .si_i       (softint_i),
    .lvl_o      (si_lvl),
    .rest_any_o (si_rest)
  );

  irq_pick #(.LVL_W(LVL_W), .TL_W(TL_W), .VEC_LIM(VEC_LIM)) u_pick (
    .pend_i   (pend_o),
    .hpriv_i  (hpriv_i),
    .ie_i     (ie_i),
    .tlz_en_i (tlz_en_i),
    .tl_i     (tl_i),
    .pil_i    (pil_i),
    .lvl_i    (si_lvl),
    .hit_o    (hit),
    .code_o   (code),
    .lvl_o    (hit_lvl)
  );

  always_comb begin
    grant = '0;
    if (take_i && hit) grant[code] = 1'b1;
    clr = grant;
    if (si_rest) clr[SRC_SOFT] = 1'b0;
  end

  assign pend_any_o = |pend_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_vld_o  <= 1'b0;
      cause_src_o  <= '0;
      cause_code_o <= '0;
      cause_lvl_o  <= '0;
    end else begin
      cause_vld_o  <= take_i && hit;
      cause_src_o  <= grant;
      cause_code_o <= (take_i && hit) ? code : '0;
      cause_lvl_o  <= (take_i && hit) ? hit_lvl : '0;
    end
  end
endmodule

// File: rtl/irq_prio_sel_chk.sv
module irq_prio_sel_chk
  import irq_sel_pkg::*;
#(
  parameter int SI_W  = 16,
  parameter int TL_W  = 3,
  parameter int LVL_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  post_i,
  input logic              take_i,
  input logic              hpriv_i,
  input logic              tlz_en_i,
  input logic [TL_W-1:0]   tl_i,
  input logic [LVL_W-1:0]  pil_i,
  input logic              cause_vld_o,
  input logic [N_SRC-1:0]  cause_src_o,
  input logic [CODE_W-1:0] cause_code_o,
  input logic [LVL_W-1:0]  cause_lvl_o,
  input logic [N_SRC-1:0]  pend_o
);
  AST_POST_SETS: assert property (@(posedge clk) disable iff (rst)
    (post_i != '0) |=> (($past(post_i) & ~pend_o) == '0)); // R1

  AST_STROBE_NEEDS_TAKE: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> !cause_vld_o); // R13

  AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    cause_vld_o |-> ($countones(cause_src_o) == 1 && cause_src_o[cause_code_o])); // R13

  AST_HPRIV_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (cause_vld_o && $past(hpriv_i)) |->
      (cause_code_o == SRC_TICK || cause_code_o == SRC_VEC)); // R3

  AST_TLZ_GATE: assert property (@(posedge clk) disable iff (rst)
    (cause_vld_o && cause_code_o == SRC_TLZ) |->
      ($past(tlz_en_i) && $past(tl_i) == '0)); // R4

  AST_SOFT_ABOVE_PIL: assert property (@(posedge clk) disable iff (rst)
    (cause_vld_o && cause_code_o == SRC_SOFT) |-> (cause_lvl_o > $past(pil_i))); // R9

  AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cause_vld_o && cause_code_o != SRC_SOFT && (($past(post_i) & cause_src_o) == '0))
      |-> ((pend_o & cause_src_o) == '0)); // R10
endmodule

bind irq_prio_sel irq_prio_sel_chk #(.SI_W(SI_W), .TL_W(TL_W), .LVL_W(LVL_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .post_i       (post_i),
  .take_i       (take_i),
  .hpriv_i      (hpriv_i),
  .tlz_en_i     (tlz_en_i),
  .tl_i         (tl_i),
  .pil_i        (pil_i),
  .cause_vld_o  (cause_vld_o),
  .cause_src_o  (cause_src_o),
  .cause_code_o (cause_code_o),
  .cause_lvl_o  (cause_lvl_o),
  .pend_o       (pend_o)
);

// File: tb/irq_prio_sel_tb.sv
module irq_prio_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic [6:0]  post_i = '0;
  logic        take_i = 1'b0;
  logic        hpriv_i = 1'b0, ie_i = 1'b0, tlz_en_i = 1'b0;
  logic [2:0]  tl_i = '0;
  logic [3:0]  pil_i = '0;
  logic [15:0] softint_i = '0;
  logic        cause_vld_o;
  logic [6:0]  cause_src_o;
  logic [2:0]  cause_code_o;
  logic [3:0]  cause_lvl_o;
  logic [6:0]  pend_o;
  logic        pend_any_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_sel dut_i (
    .clk(clk), .rst(rst), .post_i(post_i), .take_i(take_i),
    .hpriv_i(hpriv_i), .ie_i(ie_i), .tlz_en_i(tlz_en_i), .tl_i(tl_i),
    .pil_i(pil_i), .softint_i(softint_i),
    .cause_vld_o(cause_vld_o), .cause_src_o(cause_src_o),
    .cause_code_o(cause_code_o), .cause_lvl_o(cause_lvl_o),
    .pend_o(pend_o), .pend_any_o(pend_any_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected grant from the ranking rules; code 7 = nothing eligible.
  function automatic void ref_pick(input logic [6:0] f, input logic hp, input logic ie,
      input logic tz, input logic [2:0] tl, input logic [3:0] pil, input logic [15:0] si,
      output int code, output int lvl, output bit soft_clr);
    int lv = 0;
    int others = 0;
    for (int i = 1; i < 16; i++) if (si[i]) lv = i;
    for (int i = 1; i < 16; i++) if (si[i] && i != lv) others++;
    soft_clr = (others == 0);
    code = 7;
    lvl  = 0;
    if (hp) begin
      if (ie && f[1]) code = 1;
      else if (ie && f[2]) code = 2;
    end else if (f[0] && tz && tl == 0) code = 0;
    else if (f[1]) code = 1;
    else if (ie) begin
      if (f[3]) code = 3;
      else if (f[4]) code = 4;
      else if (f[6] && lv < 6 && f[2]) code = 2;
      else if (f[6] && lv > int'(pil)) begin code = 6; lvl = lv; end
      else if (f[5]) code = 5;
    end
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic do_post(input logic [6:0] f);
    @(negedge clk); post_i = f;
    @(negedge clk); post_i = '0;
  endtask

  task automatic do_take(input logic [6:0] same_post);
    @(negedge clk); take_i = 1'b1; post_i = same_post;
    @(negedge clk); take_i = 1'b0; post_i = '0;
  endtask

  initial begin
    logic [15:0] si_set [6];
    si_set[0] = 16'h0000; si_set[1] = 16'h0001; si_set[2] = 16'h0020;
    si_set[3] = 16'h0040; si_set[4] = 16'h8000; si_set[5] = 16'h0122;

    // R2: reset after activity clears everything
    do_post(7'h7F);
    check("R1 pend_any", {31'd0, pend_any_o}, 32'd1);
    check("R1 flags", {25'd0, pend_o}, 32'h7F);
    do_reset();
    check("R2 flags", {25'd0, pend_o}, 32'd0);
    check("R2 pend_any", {31'd0, pend_any_o}, 32'd0);
    check("R2 vld", {31'd0, cause_vld_o}, 32'd0);

    // R12: post and grant of same source in one cycle
    do_post(7'h01);
    hpriv_i = 0; tlz_en_i = 1; tl_i = 0; ie_i = 0;
    do_take(7'h01);
    check("R12 vld", {31'd0, cause_vld_o}, 32'd1);
    check("R12 code", {29'd0, cause_code_o}, 32'd0);
    check("R12 flag kept", {25'd0, pend_o}, 32'h01);

    // R7: bit 0 alone is no level; R10 soft flag kept while other bits remain
    do_reset();
    do_post(7'h40);
    ie_i = 1; pil_i = 0; softint_i = 16'h0001;
    do_take(7'h00);
    check("R7 bit0 ignored", {31'd0, cause_vld_o}, 32'd0);
    softint_i = 16'h0006;
    do_take(7'h00);
    check("R7 level", {28'd0, cause_lvl_o}, 32'd2);
    check("R10 soft kept", {25'd0, pend_o}, 32'h40);

    // Sweep: every flag pattern under every mode combination
    for (int p = 0; p < 128; p++)
      for (int m = 0; m < 16; m++)
        for (int s = 0; s < 6; s++)
          for (int q = 0; q < 2; q++) begin
            int ec, el; bit sc; string tag;
            logic [6:0] f, ef;
            f = 7'(p);
            hpriv_i = m[0]; ie_i = m[1]; tlz_en_i = m[2]; tl_i = m[3] ? 3'd3 : 3'd0;
            softint_i = si_set[s]; pil_i = q ? 4'd7 : 4'd0;
            ref_pick(f, hpriv_i, ie_i, tlz_en_i, tl_i, pil_i, softint_i, ec, el, sc);
            do_reset();
            do_post(f);
            do_take(7'h00);
            ef = f;
            if (ec != 7 && !(ec == 6 && !sc)) ef[ec] = 1'b0;
            case (ec)
              7: tag = "R11";
              0: tag = "R4";
              1: tag = hpriv_i ? "R3" : "R5";
              2: tag = hpriv_i ? "R3" : "R8";
              6: tag = "R9";
              default: tag = hpriv_i ? "R3" : "R6";
            endcase
            check(tag, {23'd0, cause_vld_o, cause_code_o, cause_lvl_o, cause_src_o},
                  {23'd0, (ec != 7), (ec == 7) ? 3'd0 : 3'(ec), 4'(el),
                   (ec == 7) ? 7'd0 : 7'(1 << ec)});
            check((ec == 7) ? "R11 flags" : "R10 flags", {25'd0, pend_o}, {25'd0, ef});
          end

    // R13: strobe lasts one cycle
    @(negedge clk);
    check("R13 one cycle", {31'd0, cause_vld_o}, 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule